// File: doc/BRIEF.md
# Vector Masked Transfer and Sign Test Unit

This block moves a 256-bit vector between a register value and memory under an element mask, and also evaluates a sign-bit test between two vectors. A masked load sends a single read request whose byte strobes cover only the selected elements. It returns the read data with every unselected byte forced to zero. A masked store sends a single write request whose byte strobes cover only the selected elements, so the memory side leaves all other bytes as they were. Elements are 32 or 64 bits wide. An element is selected when the top bit of its mask element is set.

Each command is accepted through a valid/ready handshake. Each transfer uses one request on a valid/ready memory port, which carries the byte address, 32 bytes of write data and 32 byte strobes, and then waits for a response pulse. The address goes out unchanged, so unaligned addresses are allowed. A transfer whose mask selects nothing produces no memory request and completes at once. The test command never touches memory: it reports a zero flag and a carry flag from the sign bits of the two operands and completes in the cycle it is accepted.

Top module: `vmx_unit`

## Requirements
- R1: The byte strobe of byte k is the top bit of the mask element that holds byte k: bit 32*(k/4)+31 of `vec_a_i` when `esize_i`=0 (32-bit elements), and bit 64*(k/8)+63 when `esize_i`=1 (64-bit elements).
- R2: Command `op_i`=2'b00 (load) with at least one selected element issues one read request (`mem_we_o`=0, `mem_wdata_o`=0) with the R1 strobes. When done, `load_data_o` byte k equals byte k of the response data if strobe k is set, and zero otherwise.
- R3: Command `op_i`=2'b01 (store) with at least one selected element issues one write request (`mem_we_o`=1) with the R1 strobes and `mem_wdata_o` equal to `vec_b_i`. Unselected bytes have strobe 0.
- R4: A load or store with no selected element issues no memory request. `done_o` is high in the same cycle that the command is accepted, and `load_data_o` is zero.
- R5: For a transfer, `done_o` is high for exactly the one cycle that follows the clock edge at which `mem_rsp_valid_i` was sampled high.
- R6: Command `op_i`=2'b10 or 2'b11 (test) issues no memory request and raises `done_o` in the cycle it is accepted. With sa and sb the element sign bits of `vec_a_i` and `vec_b_i`, `zf_o`=1 when no element has sa AND sb set, and `cf_o`=1 when no element has (NOT sa) AND sb set. Both flags are 0 whenever `done_o` is 0 or the command is not a test.
- R7: `mem_addr_o` equals the accepted `addr_i` in every bit, unaligned values included.
- R8: While `mem_req_valid_o` is high and `mem_req_ready_i` is low, the request stays valid with unchanged address, write flag, strobes and data.
- R9: After reset, `req_ready_o` is 1 and `mem_req_valid_o`, `done_o`, `zf_o`, `cf_o` and `load_data_o` are 0.
- R10: `req_ready_o` is 0 from the acceptance of a transfer until the cycle after its `done_o` pulse. Commands presented during that time are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Command valid |
| req_ready_o | output | 1 | Command can be accepted |
| op_i | input | 2 | 00 load, 01 store, 1x sign test |
| esize_i | input | 1 | Element size: 0 = 32 bit, 1 = 64 bit |
| addr_i | input | AW | Byte address of the transfer |
| vec_a_i | input | VLEN | Mask vector (transfers) or first test operand |
| vec_b_i | input | VLEN | Store data (store) or second test operand |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory request accepted |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | AW | Memory request address |
| mem_be_o | output | VLEN/8 | Memory byte strobes |
| mem_wdata_o | output | VLEN | Memory write data |
| mem_rsp_valid_i | input | 1 | Memory response pulse |
| mem_rdata_i | input | VLEN | Memory read data, valid with the response |
| done_o | output | 1 | Command complete, one cycle |
| load_data_o | output | VLEN | Zero-filled load result, valid with done |
| zf_o | output | 1 | Test zero flag, valid with done |
| cf_o | output | 1 | Test carry flag, valid with done |

## Verification
The bench targets the following corner cases:
- Masks whose low bits are dense but whose sign bits are all clear. A design that tests the whole mask word instead of its top bit would issue a pointless transaction or stall waiting for a response.
- The same mask under both element sizes. A design that mixes up the strobe replication would enable the wrong bytes or zero-fill the wrong bytes.
- Memory back-pressure and response latency that vary, with junk commands driven while a transfer is busy. A wrong design would show up here as a request that changes while held, a done pulse that is early or doubled, or a second transaction launched.
- Test operands chosen so that either flag, both flags, or neither flag is set, together with odd addresses. These would expose flipped flag logic or address alignment.

// File: rtl/vmx_pkg.sv
package vmx_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_TEST  = 2'b10,
    OP_TEST2 = 2'b11
  } vmx_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_REQ  = 2'b01,
    ST_WAIT = 2'b10
  } vmx_state_e;
endpackage

// File: rtl/vmx_mask_expand.sv
// Per-byte copy of the sign bit of the element owning that byte.
module vmx_mask_expand #(
  parameter int VLEN = 256,
  localparam int NB = VLEN / 8
) (
  input  logic [VLEN-1:0] vec_i,
  input  logic            esize_i,
  output logic [NB-1:0]   be_o
);
  for (genvar b = 0; b < NB; b++) begin : g_byte
    localparam int S32 = (b / 4) * 32 + 31;
    localparam int S64 = (b / 8) * 64 + 63;
    assign be_o[b] = esize_i ? vec_i[S64] : vec_i[S32];
  end

  logic unused_vec;
  assign unused_vec = ^vec_i;
endmodule

// File: rtl/vmx_sign_test.sv
// Works on byte-replicated sign bits; replication does not change the reductions.
module vmx_sign_test #(
  parameter int NB = 32
) (
  input  logic [NB-1:0] sa_i,
  input  logic [NB-1:0] sb_i,
  output logic          zf_o,
  output logic          cf_o
);
  assign zf_o = ~|(sa_i & sb_i);
  assign cf_o = ~|(~sa_i & sb_i);
endmodule

// File: rtl/vmx_ctrl.sv
module vmx_ctrl
  import vmx_pkg::*;
#(
  parameter int VLEN = 256,
  parameter int AW   = 32,
  localparam int NB = VLEN / 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cmd_valid_i,
  input  logic [1:0]      cmd_op_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [NB-1:0]   be_c_i,
  input  logic [VLEN-1:0] wdata_i,
  input  logic            mem_req_ready_i,
  input  logic            mem_rsp_valid_i,
  input  logic [VLEN-1:0] mem_rdata_i,
  output logic            cmd_ready_o,
  output logic            fast_done_o,
  output logic            mem_req_valid_o,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [NB-1:0]   mem_be_o,
  output logic [VLEN-1:0] mem_wdata_o,
  output logic            done_q_o,
  output logic [VLEN-1:0] data_o,
  output logic [1:0]      state_o
);
  vmx_state_e      state_q;
  vmx_op_e         op;
  logic            we_q, done_q;
  logic [AW-1:0]   addr_q;
  logic [NB-1:0]   be_q;
  logic [VLEN-1:0] wdata_q, data_q, merged;
  logic            accept, is_mem;

  assign op          = vmx_op_e'(cmd_op_i);
  assign cmd_ready_o = (state_q == ST_IDLE) && !done_q;
  assign accept      = cmd_valid_i && cmd_ready_o;
  assign is_mem      = (op == OP_LOAD || op == OP_STORE) && (|be_c_i);
  assign fast_done_o = accept && !is_mem;

  always_comb begin
    for (int b = 0; b < NB; b++)
      merged[b*8 +: 8] = be_q[b] ? mem_rdata_i[b*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      we_q    <= 1'b0;
      addr_q  <= '0;
      be_q    <= '0;
      wdata_q <= '0;
      data_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept && is_mem) begin
          state_q <= ST_REQ;
          we_q    <= (op == OP_STORE);
          addr_q  <= addr_i;
          be_q    <= be_c_i;
          wdata_q <= (op == OP_STORE) ? wdata_i : '0;
        end
        ST_REQ: if (mem_req_ready_i) state_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid_i) begin
          done_q  <= 1'b1;
          data_q  <= we_q ? '0 : merged;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_valid_o = (state_q == ST_REQ);
  assign mem_we_o        = we_q;
  assign mem_addr_o      = addr_q;
  assign mem_be_o        = be_q;
  assign mem_wdata_o     = wdata_q;
  assign done_q_o        = done_q;
  assign data_o          = done_q ? data_q : '0;
  assign state_o         = state_q;
endmodule

// File: rtl/vmx_unit.sv
module vmx_unit #(
  parameter int VLEN = 256,
  parameter int AW   = 32,
  localparam int NB = VLEN / 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic [1:0]      op_i,
  input  logic            esize_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [VLEN-1:0] vec_a_i,
  input  logic [VLEN-1:0] vec_b_i,
  output logic            mem_req_valid_o,
  input  logic            mem_req_ready_i,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [NB-1:0]   mem_be_o,
  output logic [VLEN-1:0] mem_wdata_o,
  input  logic            mem_rsp_valid_i,
  input  logic [VLEN-1:0] mem_rdata_i,
  output logic            done_o,
  output logic [VLEN-1:0] load_data_o,
  output logic            zf_o,
  output logic            cf_o
);
  logic [NB-1:0] sel_a, sel_b;
  logic          zf_c, cf_c, fast_done, done_q;
  logic [1:0]    state_q;

  vmx_mask_expand #(.VLEN(VLEN)) u_exp_a (.vec_i(vec_a_i), .esize_i(esize_i), .be_o(sel_a));
  vmx_mask_expand #(.VLEN(VLEN)) u_exp_b (.vec_i(vec_b_i), .esize_i(esize_i), .be_o(sel_b));

  vmx_sign_test #(.NB(NB)) u_test (.sa_i(sel_a), .sb_i(sel_b), .zf_o(zf_c), .cf_o(cf_c));

  vmx_ctrl #(.VLEN(VLEN), .AW(AW)) u_ctrl (
    .clk_i, .rst_ni,
    .cmd_valid_i     (req_valid_i),
    .cmd_op_i        (op_i),
    .addr_i          (addr_i),
    .be_c_i          (sel_a),
    .wdata_i         (vec_b_i),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .mem_rdata_i     (mem_rdata_i),
    .cmd_ready_o     (req_ready_o),
    .fast_done_o     (fast_done),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_we_o        (mem_we_o),
    .mem_addr_o      (mem_addr_o),
    .mem_be_o        (mem_be_o),
    .mem_wdata_o     (mem_wdata_o),
    .done_q_o        (done_q),
    .data_o          (load_data_o),
    .state_o         (state_q)
  );

  assign done_o = done_q | fast_done;
  assign zf_o   = fast_done && op_i[1] && zf_c;
  assign cf_o   = fast_done && op_i[1] && cf_c;
endmodule

// File: rtl/vmx_unit_chk.sv
module vmx_unit_chk #(
  parameter int VLEN = 256,
  parameter int AW   = 32,
  localparam int NB = VLEN / 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_ready_o,
  input logic            mem_req_valid_o,
  input logic            mem_req_ready_i,
  input logic            mem_we_o,
  input logic [AW-1:0]   mem_addr_o,
  input logic [NB-1:0]   mem_be_o,
  input logic [VLEN-1:0] mem_wdata_o,
  input logic            mem_rsp_valid_i,
  input logic            done_o,
  input logic [VLEN-1:0] load_data_o,
  input logic            zf_o,
  input logic            cf_o,
  input logic [1:0]      state_q
);
  a_r8_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_addr_o)
      && $stable(mem_be_o) && $stable(mem_we_o) && $stable(mem_wdata_o));

  a_r4_no_empty_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> (|mem_be_o));

  a_r5_done_after_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == 2'b10) && mem_rsp_valid_i |=> done_o);

  a_r5_no_done_in_flight: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != 2'b00) |-> !done_o);

  a_r10_busy_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != 2'b00) |-> !req_ready_o);

  a_r6_flags_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zf_o || cf_o) |-> done_o);

  a_r2_data_only_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> (load_data_o == '0));
endmodule

bind vmx_unit vmx_unit_chk #(.VLEN(VLEN), .AW(AW)) chk_i (
  .clk_i, .rst_ni, .req_ready_o, .mem_req_valid_o, .mem_req_ready_i, .mem_we_o,
  .mem_addr_o, .mem_be_o, .mem_wdata_o, .mem_rsp_valid_i, .done_o, .load_data_o,
  .zf_o, .cf_o, .state_q
);

// File: tb/vmx_unit_tb_top.sv
`timescale 1ns/1ps
module vmx_unit_tb_top;
  localparam int VLEN = 256;
  localparam int AW   = 32;
  localparam int NB   = VLEN / 8;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 1'b0, esize_i = 1'b0;
  logic [1:0] op_i = 2'b00;
  logic [AW-1:0] addr_i = '0;
  logic [VLEN-1:0] vec_a_i = '0, vec_b_i = '0, mem_rdata_i = '0;
  logic mem_req_ready_i = 1'b0, mem_rsp_valid_i = 1'b0;
  logic req_ready_o, mem_req_valid_o, mem_we_o, done_o, zf_o, cf_o;
  logic [AW-1:0] mem_addr_o;
  logic [NB-1:0] mem_be_o;
  logic [VLEN-1:0] mem_wdata_o, load_data_o;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk_i = ~clk_i;

  vmx_unit #(.VLEN(VLEN), .AW(AW)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input logic [VLEN-1:0] act,
                     input logic [VLEN-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [NB-1:0] exp_be(input logic [VLEN-1:0] a, input bit es);
    for (int b = 0; b < NB; b++)
      exp_be[b] = es ? a[(b/8)*64+63] : a[(b/4)*32+31];
  endfunction

  function automatic logic [1:0] exp_flags(input logic [VLEN-1:0] a, b, input bit es);
    bit z = 1, c = 1;
    int n = es ? VLEN/64 : VLEN/32;
    for (int e = 0; e < n; e++) begin
      int s = es ? e*64+63 : e*32+31;
      if (a[s] && b[s]) z = 0;
      if (!a[s] && b[s]) c = 0;
    end
    return {z, c};
  endfunction

  function automatic logic [VLEN-1:0] rnd_vec();
    for (int i = 0; i < VLEN/32; i++) rnd_vec[i*32 +: 32] = $urandom;
  endfunction

  // sign-free or sign-only patterns for boundary cases
  function automatic logic [VLEN-1:0] sign_pat(input logic [7:0] sel, input bit es);
    logic [VLEN-1:0] v = '0;
    for (int e = 0; e < (es ? VLEN/64 : VLEN/32); e++)
      if (sel[e]) v[es ? e*64+63 : e*32+31] = 1'b1;
    return v;
  endfunction

  task automatic run_op(input logic [1:0] op, input bit es, input logic [AW-1:0] addr,
                        input logic [VLEN-1:0] a, b, rd, input int hold, input int lat);
    logic [NB-1:0] be = exp_be(a, es);
    logic [VLEN-1:0] exp_ld;
    logic [1:0] fl = exp_flags(a, b, es);
    bit fast = op[1] || (be == '0);
    for (int k = 0; k < NB; k++) exp_ld[k*8 +: 8] = be[k] ? rd[k*8 +: 8] : 8'h00;
    @(negedge clk_i);
    op_i = op; esize_i = es; addr_i = addr; vec_a_i = a; vec_b_i = b; req_valid_i = 1'b1;
    #1;
    chk(req_ready_o === 1'b1, "R10 ready when idle", {255'd0, req_ready_o}, 1);
    if (fast) begin
      chk(done_o === 1'b1, op[1] ? "R6 done same cycle" : "R4 done same cycle",
          {255'd0, done_o}, 1);
      chk(load_data_o === '0, "R4 load data zero", load_data_o, '0);
      chk({zf_o, cf_o} === (op[1] ? fl : 2'b00), "R6 flags", {254'd0, zf_o, cf_o},
          op[1] ? fl : 2'b00);
      @(negedge clk_i);
      req_valid_i = 1'b0;
      #1;
      chk(mem_req_valid_o === 1'b0, "R4 no request", {255'd0, mem_req_valid_o}, 0);
      chk(done_o === 1'b0, "R4 single done", {255'd0, done_o}, 0);
      return;
    end
    chk(done_o === 1'b0, "R5 no early done", {255'd0, done_o}, 0);
    @(negedge clk_i);
    // junk command while busy (R10)
    op_i = ~op; addr_i = ~addr; vec_a_i = ~a; vec_b_i = ~b;
    #1;
    for (int h = 0; h <= hold; h++) begin
      chk(mem_req_valid_o === 1'b1, "R8 request valid", {255'd0, mem_req_valid_o}, 1);
      chk(mem_be_o === be, "R1 strobes", {224'd0, mem_be_o}, {224'd0, be});
      chk(mem_addr_o === addr, "R7 address", {224'd0, mem_addr_o}, {224'd0, addr});
      chk(mem_we_o === op[0], op[0] ? "R3 write flag" : "R2 read flag",
          {255'd0, mem_we_o}, {255'd0, op[0]});
      chk(mem_wdata_o === (op[0] ? b : '0), op[0] ? "R3 wdata" : "R2 wdata zero",
          mem_wdata_o, op[0] ? b : '0);
      chk(req_ready_o === 1'b0, "R10 busy", {255'd0, req_ready_o}, 0);
      if (h < hold) begin
        @(negedge clk_i); #1;
      end
    end
    mem_req_ready_i = 1'b1;
    @(negedge clk_i);
    mem_req_ready_i = 1'b0;
    #1;
    chk(mem_req_valid_o === 1'b0, "R8 request drops", {255'd0, mem_req_valid_o}, 0);
    for (int l = 0; l < lat; l++) begin
      chk(done_o === 1'b0, "R5 wait", {255'd0, done_o}, 0);
      @(negedge clk_i); #1;
    end
    mem_rsp_valid_i = 1'b1; mem_rdata_i = rd;
    #1;
    chk(done_o === 1'b0, "R5 not same cycle", {255'd0, done_o}, 0);
    @(negedge clk_i);
    mem_rsp_valid_i = 1'b0; mem_rdata_i = rnd_vec(); req_valid_i = 1'b0;
    #1;
    chk(done_o === 1'b1, "R5 done after rsp", {255'd0, done_o}, 1);
    chk(load_data_o === (op[0] ? '0 : exp_ld), "R2 zero-filled data", load_data_o,
        op[0] ? '0 : exp_ld);
    chk({zf_o, cf_o} === 2'b00, "R6 flags quiet", {254'd0, zf_o, cf_o}, 0);
    @(negedge clk_i); #1;
    chk(done_o === 1'b0, "R5 one cycle", {255'd0, done_o}, 0);
    chk(mem_req_valid_o === 1'b0, "R10 junk ignored", {255'd0, mem_req_valid_o}, 0);
    chk(req_ready_o === 1'b1, "R10 ready again", {255'd0, req_ready_o}, 1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    #1;
    chk(req_ready_o === 1'b1 && mem_req_valid_o === 1'b0 && done_o === 1'b0,
        "R9 reset state", {253'd0, req_ready_o, mem_req_valid_o, done_o}, 3'b100);
    rst_ni = 1'b1;
    @(negedge clk_i); #1;
    chk(load_data_o === '0 && zf_o === 1'b0 && cf_o === 1'b0, "R9 outputs zero",
        load_data_o, '0);
    // R4: low bits dense, sign bits clear
    run_op(2'b00, 0, 32'h1003, {8{32'h7fff_ffff}}, rnd_vec(), rnd_vec(), 0, 0);
    run_op(2'b01, 1, 32'h2001, {4{64'h7fff_ffff_ffff_ffff}}, rnd_vec(), rnd_vec(), 0, 0);
    // R1: same mask, both element sizes
    run_op(2'b00, 0, 32'h0000_0005, {8{32'h8000_0000}} & {4{64'h0000_0000_ffff_ffff}},
           '0, rnd_vec(), 1, 2);
    run_op(2'b00, 1, 32'h0000_0005, {8{32'h8000_0000}} & {4{64'h0000_0000_ffff_ffff}},
           '0, rnd_vec(), 0, 0);
    run_op(2'b01, 1, 32'hffff_ffff, sign_pat(8'h09, 1), rnd_vec(), '0, 2, 1);
    run_op(2'b01, 0, 32'h0000_0007, sign_pat(8'h81, 0), rnd_vec(), '0, 0, 3);
    // R6 flag corners
    run_op(2'b10, 0, '0, sign_pat(8'hff, 0), sign_pat(8'h00, 0), '0, 0, 0);
    run_op(2'b10, 0, '0, sign_pat(8'h0f, 0), sign_pat(8'hf0, 0), '0, 0, 0);
    run_op(2'b11, 1, '0, sign_pat(8'h0f, 1), sign_pat(8'h03, 1), '0, 0, 0);
    run_op(2'b10, 1, '0, sign_pat(8'h01, 1), sign_pat(8'h03, 1), '0, 0, 0);
    for (int i = 0; i < 60; i++) begin
      logic [1:0] op = 2'($urandom_range(0, 3));
      run_op(op, 1'($urandom), $urandom, rnd_vec(), rnd_vec(), rnd_vec(),
             $urandom_range(0, 3), $urandom_range(0, 3));
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule